// File: doc/BRIEF.md
# DMA Channel Register Block

This block is the host-visible register set for one DMA channel. It holds four 32-bit words: a control/status word, a transfer address, a byte count and a base word. A simple word-wide register bus reads and writes them. The block does not move data. It only keeps the state that the separate transfer engine and the attached peripheral need, and it produces the side signals that control writes imply.

The control word reflects the peripheral's interrupt level in a pending bit. The host interrupt is raised only while that bit and an enable bit are both set. A control write can do several things:
- pulse a one-cycle reset to the peripheral,
- turn the peripheral's DMA enable on or off,
- ask for a FIFO drain.

A fixed group of bits, including the version nibble, cannot be changed by the host. Writing the address word marks the channel as loaded. Each completed peripheral transfer moves the address word forward by the reported byte length.

A parameter selects a narrow 16-byte decode window or a wide 32-byte window, in which the upper half repeats the four registers.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset the control word (index 0) reads 0xA0000000, the other three words read 0, and `host_irq`, `periph_rst_pulse` and `dma_en` are low.
- R2: Byte-offset bits [3:2] select the word: 0 control, 1 address, 2 count, 3 base. An access whose offset bits [1:0] are not zero reads 0 and its write changes nothing.
- R3: With `WIDE_WINDOW`=1, offsets 16 to 31 reach the same four words as offsets 0 to 15. With `WIDE_WINDOW`=0, offsets 16 and above read 0 and ignore writes. In both variants, offsets past the window read 0 and ignore writes.
- R4: A control write leaves every bit under mask 0xFE000007 unchanged and stores the other bits from the written value. Bits [31:28] always read 0xA.
- R5: `host_irq` is high exactly while control bit 0 (pending) and bit 4 (interrupt enable) are both set.
- R6: A rising `periph_irq_lvl` sets the pending bit one clock later, and a falling level clears it. This update holds even when a control write lands in the same cycle.
- R7: A control write with bit 7 set drives `periph_rst_pulse` high for exactly the next cycle.
- R8: When a control write has bit 7 clear and bit 6 (drain) set, bit 6 is stored as 0. A written value of all zeros stores bit 6 as 1. When bit 7 is set, bit 6 is stored as written.
- R9: `dma_en` rises after a control write that sets bit 9 while it was clear. It falls after a control write that clears bit 9 while it was set. Otherwise it keeps its level.
- R10: Any write to the address word sets control bit 26 (loaded). The bit then stays set until reset.
- R11: Each cycle with `xfer_done` high adds `xfer_len` to the address word, modulo 2^32. A bus write to the address word in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| periph_irq_lvl | input | 1 | Interrupt level from the peripheral |
| xfer_done | input | 1 | One completed peripheral transfer |
| xfer_len | input | LEN_W | Byte length of that transfer |
| host_irq | output | 1 | Interrupt toward the host |
| periph_rst_pulse | output | 1 | One-cycle reset toward the peripheral |
| dma_en | output | 1 | DMA enable level toward the peripheral |

## Verification
The control word is swept over all sixteen combinations of the interrupt-enable, drain, reset and DMA-enable bits, including the all-zero value, plus all-ones and a mixed pattern. This tells apart the drain folding, the read-only masking, edge-only enable changes and the reset pulse. Plain registers get distinct patterns through every aligned, misaligned, aliased and out-of-window offset, on both window variants. This shows whether decode is by bits [3:2] alone. The address counter is stepped by several lengths across the 32-bit wrap, and once against a same-cycle bus write. Interrupt edges are applied with the enable on and off, and once together with a control write.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
  localparam int unsigned WORD_W = 32;
  localparam logic [WORD_W-1:0] RO_MASK = 32'hFE00_0007;
  localparam logic [3:0] VERSION = 4'hA;
  localparam logic [WORD_W-1:0] CTRL_RESET = {VERSION, 28'h0};

  localparam int B_PEND   = 0;
  localparam int B_IEN    = 4;
  localparam int B_DRAIN  = 6;
  localparam int B_RST    = 7;
  localparam int B_EN     = 9;
  localparam int B_LOADED = 26;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_ADDR = 2'd1,
    REG_CNT  = 2'd2,
    REG_BASE = 2'd3
  } reg_idx_e;

  // Apply the reset/drain rule to a value written by the host.
  function automatic logic [WORD_W-1:0] ctrl_fold(input logic [WORD_W-1:0] v);
    logic [WORD_W-1:0] r;
    r = v;
    if (v[B_RST]) r = v;
    else if (v[B_DRAIN]) r[B_DRAIN] = 1'b0;
    else if (v == '0) r[B_DRAIN] = 1'b1;
    return r;
  endfunction

  // Combine the old control word with a folded write value.
  function automatic logic [WORD_W-1:0] ctrl_merge(input logic [WORD_W-1:0] old,
                                                   input logic [WORD_W-1:0] v);
    logic [WORD_W-1:0] m;
    m = (old & RO_MASK) | (v & ~RO_MASK);
    return {VERSION, m[WORD_W-5:0]};
  endfunction

  function automatic logic [WORD_W-1:0] addr_advance(input logic [WORD_W-1:0] a,
                                                     input logic [WORD_W-1:0] len);
    return a + len;
  endfunction
endpackage

// File: rtl/dmach_decode.sv
module dmach_decode
  import dmach_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter bit WIDE_WINDOW = 1'b1
) (
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output reg_idx_e          idx,
  output logic [3:0]        wr_stb
);
  localparam int unsigned WIN_BYTES = WIDE_WINDOW ? 32 : 16;
  localparam logic [ADDR_W:0] WIN_LIM = (ADDR_W+1)'(WIN_BYTES);

  logic aligned;
  logic in_win;

  assign aligned = (addr[1:0] == 2'b00);
  assign in_win  = ({1'b0, addr} < WIN_LIM);
  assign hit     = sel && aligned && in_win;
  assign idx     = reg_idx_e'(addr[3:2]);

  for (genvar g = 0; g < 4; g++) begin : g_stb
    assign wr_stb[g] = hit && we && (addr[3:2] == 2'(g));
  end
endmodule

// File: rtl/dmach_ctrl.sv
module dmach_ctrl
  import dmach_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              loaded_set,
  input  logic              irq_lvl,
  output logic [WORD_W-1:0] ctrl_q,
  output logic              irq_rise,
  output logic              irq_fall,
  output logic              en_rise,
  output logic              en_fall,
  output logic              rst_pulse,
  output logic              dma_en
);
  logic              lvl_q;
  logic [WORD_W-1:0] wr_val;
  logic [WORD_W-1:0] merged;
  logic [WORD_W-1:0] ctrl_d;

  assign irq_rise = irq_lvl & ~lvl_q;
  assign irq_fall = ~irq_lvl & lvl_q;
  assign wr_val   = ctrl_fold(wdata);
  assign merged   = ctrl_merge(ctrl_q, wr_val);
  assign en_rise  = wr & wr_val[B_EN] & ~ctrl_q[B_EN];
  assign en_fall  = wr & ~wr_val[B_EN] & ctrl_q[B_EN];

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr) ctrl_d = merged;
    if (loaded_set) ctrl_d[B_LOADED] = 1'b1;
    // the interrupt level wins over anything written in the same cycle
    if (irq_rise) ctrl_d[B_PEND] = 1'b1;
    else if (irq_fall) ctrl_d[B_PEND] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q     <= 1'b0;
      ctrl_q    <= CTRL_RESET;
      rst_pulse <= 1'b0;
      dma_en    <= 1'b0;
    end else begin
      lvl_q     <= irq_lvl;
      ctrl_q    <= ctrl_d;
      rst_pulse <= wr & wr_val[B_RST];
      if (en_rise) dma_en <= 1'b1;
      else if (en_fall) dma_en <= 1'b0;
    end
  end
endmodule

// File: rtl/dmach_addr_ctr.sv
module dmach_addr_ctr
  import dmach_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              adv,
  input  logic [LEN_W-1:0]  len,
  output logic [WORD_W-1:0] addr_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) addr_q <= '0;
    else if (wr) addr_q <= wdata;
    else if (adv) addr_q <= addr_advance(addr_q, WORD_W'(len));
  end
endmodule

// File: rtl/dmach_word_reg.sv
module dmach_word_reg
  import dmach_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [WORD_W-1:0] d,
  output logic [WORD_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else if (wr) q <= d;
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dmach_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LEN_W = 16,
  parameter bit WIDE_WINDOW = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              periph_irq_lvl,
  input  logic              xfer_done,
  input  logic [LEN_W-1:0]  xfer_len,
  output logic              host_irq,
  output logic              periph_rst_pulse,
  output logic              dma_en
);
  logic        hit;
  reg_idx_e    idx;
  logic [3:0]  wr_stb;
  logic        ctrl_wr;
  logic        addr_wr;
  logic        irq_rise;
  logic        irq_fall;
  logic        en_rise;
  logic        en_fall;
  logic [WORD_W-1:0] ctrl_q;
  logic [WORD_W-1:0] addr_q;
  logic [WORD_W-1:0] plain_q [2];

  dmach_decode #(.ADDR_W(ADDR_W), .WIDE_WINDOW(WIDE_WINDOW)) u_dec (
    .sel(bus_sel), .we(bus_we), .addr(bus_addr),
    .hit(hit), .idx(idx), .wr_stb(wr_stb)
  );

  assign ctrl_wr = wr_stb[REG_CTRL];
  assign addr_wr = wr_stb[REG_ADDR];

  dmach_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(ctrl_wr), .wdata(bus_wdata),
    .loaded_set(addr_wr), .irq_lvl(periph_irq_lvl), .ctrl_q(ctrl_q),
    .irq_rise(irq_rise), .irq_fall(irq_fall), .en_rise(en_rise),
    .en_fall(en_fall), .rst_pulse(periph_rst_pulse), .dma_en(dma_en)
  );

  dmach_addr_ctr #(.LEN_W(LEN_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .wr(addr_wr), .wdata(bus_wdata),
    .adv(xfer_done), .len(xfer_len), .addr_q(addr_q)
  );

  for (genvar g = 0; g < 2; g++) begin : g_plain
    dmach_word_reg u_reg (
      .clk(clk), .rst_n(rst_n), .wr(wr_stb[g+2]), .d(bus_wdata), .q(plain_q[g])
    );
  end

  assign host_irq = ctrl_q[B_PEND] & ctrl_q[B_IEN];

  always_comb begin
    bus_rdata = '0;
    if (hit) begin
      unique case (idx)
        REG_CTRL: bus_rdata = ctrl_q;
        REG_ADDR: bus_rdata = addr_q;
        REG_CNT:  bus_rdata = plain_q[0];
        REG_BASE: bus_rdata = plain_q[1];
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/dmach_chk.sv
module dmach_chk #(
  parameter int unsigned LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctrl_wr,
  input logic             addr_wr,
  input logic [31:0]      wdata,
  input logic             xfer_done,
  input logic [LEN_W-1:0] xfer_len,
  input logic             irq_rise,
  input logic             irq_fall,
  input logic [31:0]      ctrl_q,
  input logic [31:0]      addr_q,
  input logic             host_irq,
  input logic             periph_rst_pulse,
  input logic             dma_en
);
  a_r4_version: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[31:28] == 4'hA);
  a_r4_ro_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> ctrl_q[27:25] == $past(ctrl_q[27:25]));
  a_r5_irq_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> ctrl_q[4]);
  a_r6_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rise |=> ctrl_q[0]);
  a_r6_fall_clears: assert property (@(posedge clk) disable iff (!rst_n)
    irq_fall |=> !ctrl_q[0]);
  a_r7_pulse_src: assert property (@(posedge clk) disable iff (!rst_n)
    periph_rst_pulse |-> $past(ctrl_wr && wdata[7]));
  a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_rst_pulse && !(ctrl_wr && wdata[7])) |=> !periph_rst_pulse);
  a_r9_en_rise_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_en) |-> $past(ctrl_wr && wdata[9]));
  a_r9_en_fall_src: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dma_en) |-> ($past(ctrl_wr) && !ctrl_q[9]));
  a_r10_loaded_set: assert property (@(posedge clk) disable iff (!rst_n)
    addr_wr |=> ctrl_q[26]);
  a_r10_loaded_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[26] |=> ctrl_q[26]);
  a_r11_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !addr_wr) |=> addr_q == $past(addr_q) + 32'($past(xfer_len)));
endmodule

bind dma_chan_regs dmach_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .addr_wr(addr_wr),
  .wdata(bus_wdata), .xfer_done(xfer_done), .xfer_len(xfer_len),
  .irq_rise(irq_rise), .irq_fall(irq_fall), .ctrl_q(ctrl_q), .addr_q(addr_q),
  .host_irq(host_irq), .periph_rst_pulse(periph_rst_pulse), .dma_en(dma_en)
);

// File: tb/dma_chan_regs_test.sv
module dma_chan_regs_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, nw_sel = 1'b0, bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, nw_rdata;
  logic        lvl = 1'b0, xfer_done = 1'b0;
  logic [15:0] xfer_len = '0;
  logic        host_irq, rst_pulse, dma_en;
  logic        nw_irq, nw_pulse, nw_en;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [31:0] m_ctrl, m_addr, got;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .periph_irq_lvl(lvl), .xfer_done(xfer_done), .xfer_len(xfer_len),
    .host_irq(host_irq), .periph_rst_pulse(rst_pulse), .dma_en(dma_en)
  );

  dma_chan_regs #(.WIDE_WINDOW(1'b0)) uut_nw (
    .clk(clk), .rst_n(rst_n), .bus_sel(nw_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(nw_rdata),
    .periph_irq_lvl(1'b0), .xfer_done(1'b0), .xfer_len(16'h0),
    .host_irq(nw_irq), .periph_rst_pulse(nw_pulse), .dma_en(nw_en)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 v = bus_rdata;
    bus_sel = 1'b0;
  endtask

  // Expected control word after a host write, stated from R4 and R8.
  function automatic logic [31:0] expect_ctrl(input logic [31:0] old, input logic [31:0] v);
    logic [31:0] w;
    w = v;
    if (!v[7] && v[6]) w[6] = 1'b0;
    if (v == 32'h0) w[6] = 1'b1;
    return {4'hA, old[27:25], w[24:3], old[2:0]};
  endfunction

  task automatic ctrl_write(input logic [31:0] v);
    logic [31:0] nxt;
    nxt = expect_ctrl(m_ctrl, v);
    wr(6'd0, v);
    chk("R7 pulse after write", {31'b0, rst_pulse}, {31'b0, v[7]});
    chk("R9 dma_en after write", {31'b0, dma_en}, {31'b0, nxt[9]});
    chk("R5 host_irq after write", {31'b0, host_irq}, {31'b0, nxt[0] & nxt[4]});
    m_ctrl = nxt;
    rd(6'd0, got);
    chk("R4 R8 control word", got, m_ctrl);
    chk("R7 pulse one cycle", {31'b0, rst_pulse}, 32'h0);
  endtask

  task automatic set_lvl(input logic v);
    @(negedge clk);
    lvl = v;
    @(negedge clk);
    m_ctrl[0] = v;
  endtask

  task automatic xfer(input logic [15:0] l);
    @(negedge clk);
    xfer_done = 1'b1; xfer_len = l;
    @(negedge clk);
    xfer_done = 1'b0;
    m_addr = m_addr + {16'h0, l};
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_ctrl = 32'hA000_0000;
    m_addr = 32'h0;

    // R1 reset state
    rd(6'd0, got);  chk("R1 ctrl reset", got, 32'hA000_0000);
    rd(6'd4, got);  chk("R1 addr reset", got, 32'h0);
    rd(6'd8, got);  chk("R1 count reset", got, 32'h0);
    rd(6'd12, got); chk("R1 base reset", got, 32'h0);
    chk("R1 outputs reset", {29'b0, host_irq, rst_pulse, dma_en}, 32'h0);

    // R2 plain registers with several patterns, misaligned offsets ignored
    for (int i = 0; i < 6; i++) begin
      logic [31:0] pc, pb;
      pc = 32'h1357_9BDF ^ (32'h0101_0101 * i);
      pb = ~pc + i;
      wr(6'd8, pc);
      wr(6'd12, pb);
      rd(6'd8, got);  chk("R2 count word", got, pc);
      rd(6'd12, got); chk("R2 base word", got, pb);
      wr(6'(8 + 1 + (i % 3)), 32'hDEAD_0000 + i);
      rd(6'd8, got);  chk("R2 misaligned write ignored", got, pc);
      rd(6'(8 + 1 + (i % 3)), got); chk("R2 misaligned read zero", got, 32'h0);
    end

    // R10 address write sets loaded
    wr(6'd4, 32'h0000_1000);
    m_addr = 32'h0000_1000;
    m_ctrl[26] = 1'b1;
    rd(6'd4, got); chk("R10 addr stored", got, m_addr);
    rd(6'd0, got); chk("R10 loaded set", got, m_ctrl);

    // R3 wide aliasing and out-of-window
    wr(6'd24, 32'hA5A5_0001);
    rd(6'd8, got);  chk("R3 alias write seen low", got, 32'hA5A5_0001);
    rd(6'd28, got); rd(6'd12, m_addr == 0 ? got : got);
    wr(6'd12, 32'h0BAD_CAFE);
    rd(6'd28, got); chk("R3 alias read high", got, 32'h0BAD_CAFE);
    rd(6'd20, got); chk("R3 alias addr", got, m_addr);
    wr(6'd40, 32'hFFFF_FFFF);
    rd(6'd8, got);  chk("R3 beyond window write ignored", got, 32'hA5A5_0001);
    rd(6'd40, got); chk("R3 beyond window read zero", got, 32'h0);

    // R3 narrow variant
    @(negedge clk); nw_sel = 1'b1; bus_we = 1'b1; bus_addr = 6'd24; bus_wdata = 32'h7777_7777;
    @(negedge clk); bus_addr = 6'd8; bus_wdata = 32'h0000_0055;
    @(negedge clk); bus_we = 1'b0; bus_addr = 6'd8;
    #1 chk("R3 narrow low write", nw_rdata, 32'h0000_0055);
    bus_addr = 6'd24;
    #1 chk("R3 narrow high read zero", nw_rdata, 32'h0);
    nw_sel = 1'b0;

    // R6 pending with interrupt enable clear
    set_lvl(1'b1);
    rd(6'd0, got); chk("R6 rise sets pending", got, m_ctrl);
    chk("R5 gated off", {31'b0, host_irq}, 32'h0);

    // R4 R5 R7 R8 R9 sweep over enable, drain, reset and dma-enable bits
    for (int i = 0; i < 16; i++) begin
      logic [31:0] v;
      v = (i[0] ? 32'h10 : 32'h0) | (i[1] ? 32'h40 : 32'h0) |
          (i[2] ? 32'h80 : 32'h0) | (i[3] ? 32'h200 : 32'h0);
      ctrl_write(v);
    end
    ctrl_write(32'hFFFF_FFFF);
    ctrl_write(32'h0F0F_0F0F);
    ctrl_write(32'h0000_0000);
    ctrl_write(32'h0000_0210);

    // R6 falling level clears pending, host_irq follows
    set_lvl(1'b0);
    rd(6'd0, got); chk("R6 fall clears pending", got, m_ctrl);
    chk("R5 off after fall", {31'b0, host_irq}, 32'h0);
    set_lvl(1'b1);
    chk("R5 on with enable", {31'b0, host_irq}, 32'h1);

    // R6 interrupt edge in the same cycle as a control write
    set_lvl(1'b0);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 6'd0; bus_wdata = 32'h0000_0011; lvl = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    m_ctrl = expect_ctrl(m_ctrl, 32'h0000_0011);
    m_ctrl[0] = 1'b1;
    rd(6'd0, got); chk("R6 level wins over write", got, m_ctrl);
    chk("R5 raised", {31'b0, host_irq}, 32'h1);

    // R11 address advance, wrap, and bus-write precedence
    xfer(16'h0020); xfer(16'h0004); xfer(16'hFFFF);
    rd(6'd4, got); chk("R11 advance", got, m_addr);
    wr(6'd4, 32'hFFFF_FFF0);
    m_addr = 32'hFFFF_FFF0;
    xfer(16'h0020);
    rd(6'd4, got); chk("R11 wrap", got, 32'h0000_0010);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 6'd4; bus_wdata = 32'h0000_0500;
    xfer_done = 1'b1; xfer_len = 16'h0040;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; xfer_done = 1'b0;
    rd(6'd4, got); chk("R11 bus write wins", got, 32'h0000_0500);
    rd(6'd0, got); chk("R10 loaded still set", {31'b0, got[26]}, 32'h1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule